// File: doc/BRIEF.md
# Byte ALU with Condition Flags

The block is a purely combinational arithmetic and logic unit for a small processor datapath. It takes a 4-bit operation select and two operands, A and B, and returns a result word and four condition flags: zero, negative, carry and overflow. It has no clock and no state. The surrounding pipeline registers the result and flags, and it decides whether to write them back. A compare, for example, yields a full subtract outcome, and the caller keeps only the flags.

The operations are add, subtract, compare, bitwise AND, OR and XOR, single-bit logical shifts, low-half multiply and unsigned divide. Each operation has exact carry and overflow semantics. Carry on subtract means "no borrow". A multiply sets carry when the product does not fit. Division by zero gives a defined result instead of an undefined one. Select codes with no assigned operation pass A through unchanged and keep both arithmetic flags clear, so the caller can ignore them without risk.

The operand width is a parameter with a default of 8. A second parameter chooses how the divider is built: either a combinational restoring array or the language's division operator.

Top module: `byte_alu`

## Requirements
- R1: Select 0 (add) returns (A+B) mod 2^W. Carry is set when the true sum exceeds 2^W-1. Overflow is set when the sign bit of A and the sign bit of B both differ from the sign bit of the result.
- R2: Select 1 (subtract) and select 9 (compare) both return (A-B) mod 2^W with identical flags. Carry is set when A >= B, read as unsigned. Overflow is set when A and B differ in sign and the result's sign differs from A's.
- R3: Selects 2, 3 and 4 return A AND B, A OR B and A XOR B respectively. All three clear carry and overflow.
- R4: Select 5 shifts A left by one place and fills bit 0 with zero. Carry takes A's top bit, overflow is cleared, and B has no effect on any output.
- R5: Select 6 shifts A right by one place as a logical shift, so the top bit becomes zero. Carry takes A's bit 0, overflow is cleared, and B has no effect on any output.
- R6: Select 7 returns the low W bits of A*B. Carry is set when the full product exceeds 2^W-1, and overflow is cleared.
- R7: Select 8 with B nonzero returns the unsigned quotient floor(A/B), with carry and overflow cleared.
- R8: Select 8 with B equal to zero returns 0, and sets both carry and overflow.
- R9: For every select, zero is set exactly when the W-bit result is all zeros, and negative equals result bit W-1.
- R10: Selects 10 to 15 return A unchanged, with carry and overflow cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation select (encodings in R1-R10) |
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| res_o | output | WIDTH | Result word |
| zero_o | output | 1 | Result is all zeros |
| neg_o | output | 1 | Copy of the result's top bit |
| carry_o | output | 1 | Carry / no-borrow / product-overflow / divide-by-zero indication |
| ovf_o | output | 1 | Signed overflow, or divide-by-zero indication |

## Verification
The checker assumes that the select and both operands hold known two-state values, and that the outputs have settled before each property is evaluated. It relies on this because the block is evaluated as soon as its inputs change. The bench drives only 0/1 values and changes the inputs only between sample points. It covers every select code, including the six unassigned ones, and for each code it sweeps every pair of 8-bit operands. Because of this sweep, zero divisors, sign-boundary operands and products that do not fit are all reached without special setup.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

   localparam int OPC_W = 4;

   typedef enum logic [OPC_W-1:0] {
      ALU_ADD = 4'd0,
      ALU_SUB = 4'd1,
      ALU_AND = 4'd2,
      ALU_OR  = 4'd3,
      ALU_XOR = 4'd4,
      ALU_SHL = 4'd5,
      ALU_SHR = 4'd6,
      ALU_MUL = 4'd7,
      ALU_DIV = 4'd8,
      ALU_CMP = 4'd9
   } alu_op_e;

   typedef struct packed {
      logic zero;
      logic neg;
      logic carry;
      logic ovf;
   } alu_flags_t;

endpackage

// File: rtl/byte_alu_addsub.sv
// Shared adder for add, subtract and compare.
// In subtract mode B is inverted and a carry-in of 1 is added,
// so carry-out reads as "no borrow".
module byte_alu_addsub #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             sub_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             carry_o,
   output logic             ovf_o
);

   logic [WIDTH-1:0] b_eff;
   logic [WIDTH:0]   wide_sum;

   assign b_eff    = sub_i ? ~b_i : b_i;
   assign wide_sum = {1'b0, a_i} + {1'b0, b_eff} + (WIDTH+1)'(sub_i);
   assign sum_o    = wide_sum[WIDTH-1:0];
   assign carry_o  = wide_sum[WIDTH];

   // Signed overflow: the two adder inputs agree in sign, but the sum does not.
   assign ovf_o = (a_i[WIDTH-1] == b_eff[WIDTH-1]) &&
                  (sum_o[WIDTH-1] != a_i[WIDTH-1]);

endmodule

// File: rtl/byte_alu_divider.sv
// Unsigned quotient. IMPL 0 builds a restoring array, one compare and
// subtract stage per quotient bit. IMPL 1 uses the division operator.
// A zero divisor gives all ones here; the top module overrides that case.
module byte_alu_divider #(
   parameter int WIDTH = 8,
   parameter int IMPL  = 0
) (
   input  logic [WIDTH-1:0] num_i,
   input  logic [WIDTH-1:0] den_i,
   output logic [WIDTH-1:0] quot_o
);

   if (IMPL == 0) begin : g_array
      logic [WIDTH-1:0] rem_q [WIDTH+1];
      assign rem_q[0] = '0;

      for (genvar k = 0; k < WIDTH; k++) begin : g_stage
         localparam int BIT = WIDTH - 1 - k;
         logic [WIDTH:0] shifted;
         logic [WIDTH:0] diff;
         logic           ge;
         logic           unused_diff_top;

         assign shifted         = {rem_q[k], num_i[BIT]};
         assign ge              = shifted >= {1'b0, den_i};
         assign diff            = shifted - {1'b0, den_i};
         assign quot_o[BIT]     = ge;
         assign rem_q[k+1]      = ge ? diff[WIDTH-1:0] : shifted[WIDTH-1:0];
         assign unused_diff_top = diff[WIDTH];
      end

      logic unused_final_rem;
      assign unused_final_rem = ^rem_q[WIDTH];
   end else begin : g_operator
      assign quot_o = (den_i == '0) ? '1 : num_i / den_i;
   end

endmodule

// File: rtl/byte_alu.sv
module byte_alu
   import byte_alu_pkg::*;
#(
   parameter int WIDTH    = 8,
   parameter int DIV_IMPL = 0
) (
   input  logic [OPC_W-1:0] op_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] res_o,
   output logic             zero_o,
   output logic             neg_o,
   output logic             carry_o,
   output logic             ovf_o
);

   localparam int PROD_W = 2 * WIDTH;

   if (WIDTH < 2) begin : g_bad_width
      $error("byte_alu: WIDTH must be at least 2");
   end
   if (DIV_IMPL != 0 && DIV_IMPL != 1) begin : g_bad_div
      $error("byte_alu: DIV_IMPL must be 0 or 1");
   end

   logic             is_sub;
   logic [WIDTH-1:0] as_sum;
   logic             as_carry;
   logic             as_ovf;
   logic [PROD_W-1:0] prod;
   logic [WIDTH-1:0] quot;
   logic [WIDTH-1:0] res;
   alu_flags_t       flg;

   assign is_sub = (op_i == ALU_SUB) || (op_i == ALU_CMP);

   byte_alu_addsub #(.WIDTH(WIDTH)) addsub_i (
      .a_i     (a_i),
      .b_i     (b_i),
      .sub_i   (is_sub),
      .sum_o   (as_sum),
      .carry_o (as_carry),
      .ovf_o   (as_ovf)
   );

   assign prod = {{WIDTH{1'b0}}, a_i} * {{WIDTH{1'b0}}, b_i};

   byte_alu_divider #(.WIDTH(WIDTH), .IMPL(DIV_IMPL)) div_i (
      .num_i  (a_i),
      .den_i  (b_i),
      .quot_o (quot)
   );

   always_comb begin
      res       = a_i;
      flg.carry = 1'b0;
      flg.ovf   = 1'b0;
      case (alu_op_e'(op_i))
         ALU_ADD, ALU_SUB, ALU_CMP: begin
            res       = as_sum;
            flg.carry = as_carry;
            flg.ovf   = as_ovf;
         end
         ALU_AND: res = a_i & b_i;
         ALU_OR:  res = a_i | b_i;
         ALU_XOR: res = a_i ^ b_i;
         ALU_SHL: begin
            res       = {a_i[WIDTH-2:0], 1'b0};
            flg.carry = a_i[WIDTH-1];
         end
         ALU_SHR: begin
            res       = {1'b0, a_i[WIDTH-1:1]};
            flg.carry = a_i[0];
         end
         ALU_MUL: begin
            res       = prod[WIDTH-1:0];
            flg.carry = |prod[PROD_W-1:WIDTH];
         end
         ALU_DIV: begin
            if (b_i == '0) begin
               res       = '0;
               flg.carry = 1'b1;
               flg.ovf   = 1'b1;
            end else begin
               res = quot;
            end
         end
         default: res = a_i;
      endcase
      flg.zero = ~|res;
      flg.neg  = res[WIDTH-1];
   end

   assign res_o   = res;
   assign zero_o  = flg.zero;
   assign neg_o   = flg.neg;
   assign carry_o = flg.carry;
   assign ovf_o   = flg.ovf;

endmodule

// File: rtl/byte_alu_chk.sv
module byte_alu_chk
   import byte_alu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input logic [OPC_W-1:0] op_i,
   input logic [WIDTH-1:0] a_i,
   input logic [WIDTH-1:0] b_i,
   input logic [WIDTH-1:0] res_o,
   input logic             zero_o,
   input logic             neg_o,
   input logic             carry_o,
   input logic             ovf_o
);

   logic [2*WIDTH-1:0] back_prod;
   logic [2*WIDTH-1:0] a_wide;
   logic [2*WIDTH-1:0] b_wide;

   assign a_wide    = {{WIDTH{1'b0}}, a_i};
   assign b_wide    = {{WIDTH{1'b0}}, b_i};
   assign back_prod = {{WIDTH{1'b0}}, res_o} * b_wide;

   always_comb begin
      a_r9_zero_flag: assert (zero_o == (res_o == '0))
         else $error("zero flag disagrees with result");
      a_r9_neg_flag: assert (neg_o == res_o[WIDTH-1])
         else $error("negative flag disagrees with result");

      if (op_i == ALU_SUB || op_i == ALU_CMP) begin
         a_r2_no_borrow: assert (carry_o == (a_i >= b_i))
            else $error("subtract carry is not no-borrow");
      end
      if (op_i == ALU_AND || op_i == ALU_OR || op_i == ALU_XOR) begin
         a_r3_logic_clear: assert (!carry_o && !ovf_o)
            else $error("logic op left carry/overflow set");
      end
      if (op_i == ALU_SHL) begin
         a_r4_shl_carry: assert (carry_o == a_i[WIDTH-1] && !res_o[0] && !ovf_o)
            else $error("left shift carry/fill wrong");
      end
      if (op_i == ALU_SHR) begin
         a_r5_shr_carry: assert (carry_o == a_i[0] && !res_o[WIDTH-1] && !ovf_o)
            else $error("right shift carry/fill wrong");
      end
      if (op_i == ALU_MUL) begin
         a_r6_no_overflow: assert (!ovf_o)
            else $error("multiply set overflow");
      end
      if (op_i == ALU_DIV && b_i != '0) begin
         a_r7_quot_bound: assert (back_prod <= a_wide && (a_wide - back_prod) < b_wide)
            else $error("quotient out of bounds");
      end
      if (op_i == ALU_DIV && b_i == '0) begin
         a_r8_div_zero: assert (res_o == '0 && carry_o && ovf_o)
            else $error("divide by zero handling wrong");
      end
      if (op_i >= 4'd10) begin
         a_r10_pass_a: assert (res_o == a_i && !carry_o && !ovf_o)
            else $error("unassigned select did not pass A");
      end
   end

endmodule

bind byte_alu byte_alu_chk #(.WIDTH(WIDTH)) chk_i (
   .op_i    (op_i),
   .a_i     (a_i),
   .b_i     (b_i),
   .res_o   (res_o),
   .zero_o  (zero_o),
   .neg_o   (neg_o),
   .carry_o (carry_o),
   .ovf_o   (ovf_o)
);

// File: tb/byte_alu_tb_top.sv
module byte_alu_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG_CYCLES = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] op_i = '0;
   logic [7:0] a_i = '0;
   logic [7:0] b_i = '0;
   logic [7:0] res_o;
   logic       zero_o, neg_o, carry_o, ovf_o;

   int n_checks = 0;
   int n_fails  = 0;
   int cycles   = 0;
   bit finished = 1'b0;

   byte_alu dut_i (
      .op_i    (op_i),
      .a_i     (a_i),
      .b_i     (b_i),
      .res_o   (res_o),
      .zero_o  (zero_o),
      .neg_o   (neg_o),
      .carry_o (carry_o),
      .ovf_o   (ovf_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // Expected {res[7:0], z, n, c, v}, computed arithmetically.
   function automatic logic [11:0] model(int op, int a, int b);
      int r, c, v, full;
      r = a; c = 0; v = 0;
      case (op)
         0: begin full = a + b; r = full & 255; c = (full > 255);
                  v = (((a ^ r) & (b ^ r) & 128) != 0); end
         1, 9: begin r = (a - b) & 255; c = (a >= b);
                  v = (((a ^ b) & (a ^ r) & 128) != 0); end
         2: r = a & b;
         3: r = a | b;
         4: r = a ^ b;
         5: begin r = (a * 2) & 255; c = (a >= 128); end
         6: begin r = a / 2; c = a % 2; end
         7: begin full = a * b; r = full & 255; c = (full > 255); end
         8: begin
               if (b == 0) begin r = 0; c = 1; v = 1; end
               else r = a / b;
            end
         default: r = a;
      endcase
      return {r[7:0], (r == 0) ? 1'b1 : 1'b0, r[7], c[0], v[0]};
   endfunction

   function automatic string tag(int op, int b);
      case (op)
         0: return "R1";
         1, 9: return "R2";
         2, 3, 4: return "R3";
         5: return "R4";
         6: return "R5";
         7: return "R6";
         8: return (b == 0) ? "R8" : "R7";
         default: return "R10";
      endcase
   endfunction

   task automatic check_vec(int op, int a, int b);
      logic [11:0] exp_v;
      exp_v = model(op, a, b);
      n_checks++;
      if ({res_o, carry_o, ovf_o} != {exp_v[11:4], exp_v[1:0]}) begin
         n_fails++;
         $display("FAIL %s op=%0d a=%0d b=%0d actual res=%0d c=%0b v=%0b expected res=%0d c=%0b v=%0b",
                  tag(op, b), op, a, b, res_o, carry_o, ovf_o, exp_v[11:4], exp_v[1], exp_v[0]);
      end
      n_checks++;
      if ({zero_o, neg_o} != exp_v[3:2]) begin
         n_fails++;
         $display("FAIL R9 op=%0d a=%0d b=%0d actual z=%0b n=%0b expected z=%0b n=%0b",
                  op, a, b, zero_o, neg_o, exp_v[3], exp_v[2]);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > WATCHDOG_CYCLES && !finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
         finish_run();
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // Idle state: add of zeros gives a zero result with Z set (R1, R9).
      #1;
      check_vec(0, 0, 0);
      // Full sweep of every select over every operand pair.
      // It covers R1-related adds, R2 sub/compare, R3 logic, R4/R5 shifts
      // with B ignored, R6 multiply, R7 quotients, R8 zero divisor,
      // R9 flags and R10 pass-through.
      for (int op = 0; op < 16; op++) begin
         for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
               op_i = op[3:0];
               a_i  = a[7:0];
               b_i  = b[7:0];
               #1;
               check_vec(op, a, b);
            end
         end
      end
      finish_run();
   end

endmodule